// File: doc/BRIEF.md
# Per-ID Read Traffic Monitor

This block counts the read requests that a shared last-level cache sends out to the rest of the system. Each request is charged to a monitoring identifier (a 10-bit RMID). The identifier is taken from the association register of the hardware thread that caused the request. The block does not hold one counter pair per legal identifier. Instead it has a small pool of tracking slots. Each slot holds an identifier, a count of all outgoing reads and a count of the reads served by the local memory node. A slot is claimed whenever a thread is given an identifier that no slot is tracking yet.

Software works through one request/response register port. It writes an identifier into a thread's association register. To read a count, it writes an identifier and an event code into the selection register, then reads the counter register. That 64-bit word carries the count together with an error flag and an unavailable flag. Every request is answered one cycle after it is issued. Reads that go to I/O space arrive on the event port with a flag set and are never counted.

Top module: `rmid_bw_monitor`

## Requirements
- R1: After reset, every thread association register holds RMID 0. The selection register is all zero. Only RMID 0 is tracked, and both of its counts are zero.
- R2: Register map. Addresses 0 to N_THREADS-1 are the thread association registers, with the RMID in bits 9:0. Address 0xE is the selection register, with the event code in bits 7:0 and the RMID in bits 41:32. A write with any other bit set, or with an RMID above MAX_RMID_ALL (255), gets an error response and leaves the register unchanged.
- R3: Each request gets rsp_valid exactly one cycle later, and no response appears without a request. A write response carries zero data. A write to the counter register (0xF), or any access to an unmapped address, gets an error response and changes nothing.
- R4: An event with ev_io low adds one to the total count of the slot tracking its thread's current RMID. It also adds one to that slot's local count when ev_local is high. An event with ev_io high changes no count.
- R5: The counter word at 0xF has the error flag in bit 63 and the unavailable flag in bit 62. Bits 61 down to CNT_W are zero, and the count sits in bits CNT_W-1:0. Event code 2 selects the total count and code 3 selects the local count.
- R6: If the selected event code is not 1, 2 or 3, or the selected RMID exceeds MAX_RMID_BW (63), the counter word has bit 63 set and every other bit clear.
- R7: If neither condition of R6 applies, event code 1 (occupancy, not measured by this block) and any RMID held in no slot both return bit 62 set and every other bit clear.
- R8: An accepted association write whose RMID is not tracked claims a slot and starts both of its counts at zero. Writing an RMID that is already tracked keeps its slot and counts.
- R9: A new RMID takes the lowest-index empty slot. If no slot is empty, it takes the lowest-index slot whose RMID no thread holds once the write is applied. Every RMID held by a thread is always tracked by exactly one slot.
- R10: Counts wrap from 2^CNT_W-1 to 0 and keep counting.
- R11: A read returns the state from before any update in the same cycle. An event is charged to the thread's RMID before any same-cycle association write. If the slot it would count into is claimed in that same cycle, the claim wins and the counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register address |
| req_wdata | input | 64 | Write data |
| ev_valid | input | 1 | A read request left the cache |
| ev_thread | input | TID_W | Thread that caused the request |
| ev_local | input | 1 | Request was served by the local node |
| ev_io | input | 1 | Request targets I/O space (not counted) |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Request rejected |
| rsp_rdata | output | 64 | Read data, zero for writes |

## Verification
Every register result is due on the response port in the cycle after the request edge. Count changes from events, and slot claims from association writes, land at the same edge, so they can be seen in the counter read issued on the next cycle. The bench drives each request on a falling edge and advances its model at the following rising edge. It compares the response on the next falling edge against a value computed from the model's state before that update. This also pins down the same-cycle order of R11.

// File: rtl/rmbw_pkg.sv
// Shared constants for the per-ID read traffic monitor: register
// addresses that are not per-thread, and event codes.
package rmbw_pkg;
    localparam int          ADDR_W      = 4;
    localparam logic [3:0]  ADDR_EVTSEL = 4'hE;
    localparam logic [3:0]  ADDR_CTR    = 4'hF;
    localparam logic [7:0]  EVT_OCC     = 8'd1;
    localparam logic [7:0]  EVT_TOT     = 8'd2;
    localparam logic [7:0]  EVT_LOC     = 8'd3;
    localparam int          SEL_RMID_LSB = 32;
endpackage

// File: rtl/rmbw_regs.sv
// Thread association registers and the selection register.
// Checks each write for reserved bits and for an RMID above the
// global limit. Only accepted writes update state.
// Assumes the addresses of the association registers start at 0.
module rmbw_regs #(
    parameter int N_THREADS    = 4,
    parameter int RMID_W       = 10,
    parameter int MAX_RMID_ALL = 255
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [3:0]                        addr,
    input  logic [63:0]                       wdata,
    output logic [N_THREADS-1:0][RMID_W-1:0]  asn_rmid,
    output logic [N_THREADS-1:0]              asn_we,
    output logic [RMID_W-1:0]                 new_rmid,
    output logic [7:0]                        sel_evt,
    output logic [RMID_W-1:0]                 sel_rmid,
    output logic                              wr_accept
);
    import rmbw_pkg::*;

    localparam logic [RMID_W-1:0] RMID_LIM = RMID_W'(MAX_RMID_ALL);
    localparam logic [3:0]        THR_LIM  = 4'(N_THREADS);
    localparam int                SEL_TOP  = SEL_RMID_LSB + RMID_W;

    logic              hit_asn, hit_sel, asn_ok, sel_ok;
    logic [RMID_W-1:0] sel_field;

    // Decode the target and check the fields of a write.
    always_comb begin
        hit_asn   = addr < THR_LIM;
        hit_sel   = addr == ADDR_EVTSEL;
        new_rmid  = wdata[RMID_W-1:0];
        sel_field = wdata[SEL_RMID_LSB +: RMID_W];
        asn_ok    = (wdata[63:RMID_W] == '0) && (new_rmid <= RMID_LIM);
        sel_ok    = (wdata[31:8] == '0) && (wdata[63:SEL_TOP] == '0)
                    && (sel_field <= RMID_LIM);
        wr_accept = wr_en && ((hit_asn && asn_ok) || (hit_sel && sel_ok));
    end

    for (genvar t = 0; t < N_THREADS; t++) begin : g_thr
        assign asn_we[t] = wr_en && hit_asn && asn_ok && (addr == 4'(t));

        // Hold one thread's RMID.
        always_ff @(posedge clk) begin
            if (!rst_n)         asn_rmid[t] <= '0;
            else if (asn_we[t]) asn_rmid[t] <= new_rmid;
        end

        a_r2_asn_in_range: assert property (@(posedge clk) disable iff (!rst_n)
            asn_rmid[t] <= RMID_LIM);
    end

    // Hold the selected event code and RMID.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_evt  <= '0;
            sel_rmid <= '0;
        end else if (wr_en && hit_sel && sel_ok) begin
            sel_evt  <= wdata[7:0];
            sel_rmid <= sel_field;
        end
    end

    a_r2_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_accept) |=> ($stable(sel_evt) && $stable(sel_rmid) && $stable(asn_rmid)));
endmodule

// File: rtl/rmbw_alloc.sv
// Picks the slot for a newly assigned RMID. The lowest empty slot
// is taken first. Failing that, the lowest slot whose RMID no thread
// holds after the write. Purely combinational. Assumes N_SLOTS is
// larger than N_THREADS, so a victim always exists.
module rmbw_alloc #(
    parameter int N_THREADS = 4,
    parameter int N_SLOTS   = 8,
    parameter int RMID_W    = 10
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [N_SLOTS-1:0]                slot_vld,
    input  logic [N_SLOTS-1:0][RMID_W-1:0]    slot_rmid,
    input  logic [N_THREADS-1:0][RMID_W-1:0]  asn_rmid,
    input  logic [N_THREADS-1:0]              asn_we,
    input  logic [RMID_W-1:0]                 new_rmid,
    output logic [N_SLOTS-1:0]                alloc_sel
);
    logic [N_THREADS-1:0][RMID_W-1:0] post;
    logic [N_SLOTS-1:0]               held, cand, pick;
    logic                             present, need;

    // Compute the thread RMIDs as they stand after this cycle's write.
    always_comb begin
        for (int t = 0; t < N_THREADS; t++)
            post[t] = asn_we[t] ? new_rmid : asn_rmid[t];
    end

    // Find out whether the new RMID is tracked and which slots are held.
    always_comb begin
        present = 1'b0;
        for (int s = 0; s < N_SLOTS; s++) begin
            held[s] = 1'b0;
            if (slot_vld[s] && slot_rmid[s] == new_rmid) present = 1'b1;
            for (int t = 0; t < N_THREADS; t++)
                if (post[t] == slot_rmid[s]) held[s] = 1'b1;
        end
        need = (|asn_we) && !present;
    end

    // Choose the lowest-index candidate: empty slots first, then unheld ones.
    always_comb begin
        cand      = (|(~slot_vld)) ? ~slot_vld : (slot_vld & ~held);
        pick      = cand & (~cand + 1'b1);
        alloc_sel = need ? pick : '0;
    end

    a_r9_victim_found: assert property (@(posedge clk) disable iff (!rst_n)
        need |-> (alloc_sel != '0));
endmodule

// File: rtl/rmbw_slots.sv
// The tracking slots. Each slot holds an RMID, a valid bit, a total
// count and a local-node count. A claim clears the counts and takes
// priority over counting in the same cycle. Slot 0 comes out of
// reset tracking RMID 0.
module rmbw_slots #(
    parameter int N_SLOTS = 8,
    parameter int RMID_W  = 10,
    parameter int CNT_W   = 24
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [N_SLOTS-1:0]              alloc_sel,
    input  logic [RMID_W-1:0]               alloc_rmid,
    input  logic                            cnt_en,
    input  logic [RMID_W-1:0]               cnt_rmid,
    input  logic                            cnt_local,
    output logic [N_SLOTS-1:0]              slot_vld,
    output logic [N_SLOTS-1:0][RMID_W-1:0]  slot_rmid,
    output logic [N_SLOTS-1:0][CNT_W-1:0]   slot_tot,
    output logic [N_SLOTS-1:0][CNT_W-1:0]   slot_loc
);
    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        logic hit;
        assign hit = cnt_en && slot_vld[s] && (slot_rmid[s] == cnt_rmid);

        // Claim, clear or advance one slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_vld[s]  <= (s == 0);
                slot_rmid[s] <= '0;
                slot_tot[s]  <= '0;
                slot_loc[s]  <= '0;
            end else if (alloc_sel[s]) begin
                slot_vld[s]  <= 1'b1;
                slot_rmid[s] <= alloc_rmid;
                slot_tot[s]  <= '0;
                slot_loc[s]  <= '0;
            end else if (hit) begin
                slot_tot[s]  <= slot_tot[s] + 1'b1;
                if (cnt_local) slot_loc[s] <= slot_loc[s] + 1'b1;
            end
        end

        a_r8_claim_clears: assert property (@(posedge clk) disable iff (!rst_n)
            alloc_sel[s] |=> (slot_vld[s] && slot_tot[s] == '0 && slot_loc[s] == '0));

        a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
            !alloc_sel[s] |=> (slot_tot[s] == $past(slot_tot[s])
                               || slot_tot[s] == $past(slot_tot[s]) + 1'b1));
    end
endmodule

// File: rtl/rmid_bw_monitor.sv
// Top of the per-ID read traffic monitor. Ties together the
// registers, the slot chooser and the slot bank. It builds the
// counter word and registers every response one cycle after its
// request. Assumes N_SLOTS > N_THREADS and CNT_W <= 62.
module rmid_bw_monitor #(
    parameter int N_THREADS    = 4,
    parameter int N_SLOTS      = 8,
    parameter int CNT_W        = 24,
    parameter int RMID_W       = 10,
    parameter int MAX_RMID_ALL = 255,
    parameter int MAX_RMID_BW  = 63,
    parameter int TID_W        = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [3:0]        req_addr,
    input  logic [63:0]       req_wdata,
    input  logic              ev_valid,
    input  logic [TID_W-1:0]  ev_thread,
    input  logic              ev_local,
    input  logic              ev_io,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [63:0]       rsp_rdata
);
    import rmbw_pkg::*;

    localparam logic [RMID_W-1:0] BW_LIM  = RMID_W'(MAX_RMID_BW);
    localparam logic [3:0]        THR_LIM = 4'(N_THREADS);

    logic [N_THREADS-1:0][RMID_W-1:0] asn_rmid;
    logic [N_THREADS-1:0]             asn_we;
    logic [RMID_W-1:0]                new_rmid, sel_rmid;
    logic [7:0]                       sel_evt;
    logic                             wr_accept;
    logic [N_SLOTS-1:0]               alloc_sel, slot_vld;
    logic [N_SLOTS-1:0][RMID_W-1:0]   slot_rmid;
    logic [N_SLOTS-1:0][CNT_W-1:0]    slot_tot, slot_loc;
    logic                             cnt_en;
    logic [RMID_W-1:0]                cnt_rmid;

    rmbw_regs #(
        .N_THREADS(N_THREADS), .RMID_W(RMID_W), .MAX_RMID_ALL(MAX_RMID_ALL)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(req_valid && req_write),
        .addr(req_addr), .wdata(req_wdata), .asn_rmid(asn_rmid),
        .asn_we(asn_we), .new_rmid(new_rmid), .sel_evt(sel_evt),
        .sel_rmid(sel_rmid), .wr_accept(wr_accept)
    );

    rmbw_alloc #(
        .N_THREADS(N_THREADS), .N_SLOTS(N_SLOTS), .RMID_W(RMID_W)
    ) u_alloc (
        .clk(clk), .rst_n(rst_n), .slot_vld(slot_vld), .slot_rmid(slot_rmid),
        .asn_rmid(asn_rmid), .asn_we(asn_we), .new_rmid(new_rmid),
        .alloc_sel(alloc_sel)
    );

    // Charge an event to the thread's RMID as it stands before any write.
    assign cnt_en   = ev_valid && !ev_io;
    assign cnt_rmid = asn_rmid[ev_thread];

    rmbw_slots #(
        .N_SLOTS(N_SLOTS), .RMID_W(RMID_W), .CNT_W(CNT_W)
    ) u_slots (
        .clk(clk), .rst_n(rst_n), .alloc_sel(alloc_sel), .alloc_rmid(new_rmid),
        .cnt_en(cnt_en), .cnt_rmid(cnt_rmid), .cnt_local(ev_local),
        .slot_vld(slot_vld), .slot_rmid(slot_rmid),
        .slot_tot(slot_tot), .slot_loc(slot_loc)
    );

    logic              sel_hit, ev_bad, ev_na, rd_err;
    logic [CNT_W-1:0]  sel_tot, sel_loc;
    logic [63:0]       ctr_word, rd_word;

    // Look up the selected RMID and build the counter word.
    always_comb begin
        sel_hit = 1'b0;
        sel_tot = '0;
        sel_loc = '0;
        for (int s = 0; s < N_SLOTS; s++) begin
            if (slot_vld[s] && slot_rmid[s] == sel_rmid) begin
                sel_hit = 1'b1;
                sel_tot = slot_tot[s];
                sel_loc = slot_loc[s];
            end
        end
        ev_bad = !(sel_evt == EVT_OCC || sel_evt == EVT_TOT || sel_evt == EVT_LOC)
                 || (sel_rmid > BW_LIM);
        ev_na  = !ev_bad && (sel_evt == EVT_OCC || !sel_hit);
        ctr_word     = '0;
        ctr_word[63] = ev_bad;
        ctr_word[62] = ev_na;
        if (!ev_bad && !ev_na)
            ctr_word[CNT_W-1:0] = (sel_evt == EVT_TOT) ? sel_tot : sel_loc;
    end

    // Pick the read data for the addressed register.
    always_comb begin
        rd_word = '0;
        rd_err  = 1'b0;
        if (req_addr < THR_LIM) begin
            rd_word[RMID_W-1:0] = asn_rmid[req_addr[TID_W-1:0]];
        end else if (req_addr == ADDR_EVTSEL) begin
            rd_word[7:0]                   = sel_evt;
            rd_word[SEL_RMID_LSB +: RMID_W] = sel_rmid;
        end else if (req_addr == ADDR_CTR) begin
            rd_word = ctr_word;
        end else begin
            rd_err = 1'b1;
        end
    end

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && (req_write ? !wr_accept : rd_err);
            rsp_rdata <= (req_valid && !req_write) ? rd_word : '0;
        end
    end

    for (genvar t = 0; t < N_THREADS; t++) begin : g_chk
        logic [N_SLOTS-1:0] trk;
        always_comb begin
            for (int s = 0; s < N_SLOTS; s++)
                trk[s] = slot_vld[s] && (slot_rmid[s] == asn_rmid[t]);
        end
        a_r9_held_tracked: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(trk) == 1);
    end

    a_r3_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r6_err_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_rdata[63]) |-> (rsp_rdata[62:0] == '0));

    a_r7_unavail_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_rdata[62]) |-> (!rsp_rdata[63] && rsp_rdata[61:0] == '0));
endmodule

// File: tb/test_rmid_bw_monitor.sv
// Self-checking bench: directed corner cases, then seeded random traffic
// checked against a behavioural model of the slots and registers.
module test_rmid_bw_monitor;
    localparam int CW  = 6;
    localparam int MSK = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        ev_valid = 1'b0, ev_local = 1'b0, ev_io = 1'b0;
    logic [1:0]  ev_thread = '0;
    logic        rsp_valid, rsp_err;
    logic [63:0] rsp_rdata;

    int n_chk = 0, n_bad = 0;

    rmid_bw_monitor #(.CNT_W(CW)) i_rmid_bw_monitor (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .ev_valid(ev_valid),
        .ev_thread(ev_thread), .ev_local(ev_local), .ev_io(ev_io),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    always #2.5 clk = ~clk;

    // model state
    int m_asn[4];
    int m_evt, m_srm;
    bit m_vld[8];
    int m_rm[8], m_tot[8], m_loc[8];

    function automatic int find(input int r);
        for (int s = 0; s < 8; s++) if (m_vld[s] && m_rm[s] == r) return s;
        return -1;
    endfunction

    function automatic bit wr_ok(input logic [3:0] a, input logic [63:0] d);
        if (a < 4)     return (d[63:10] == 0) && (d[9:0] <= 255);
        if (a == 4'hE) return (d[31:8] == 0) && (d[63:42] == 0) && (d[41:32] <= 255);
        return 1'b0;
    endfunction

    function automatic logic [63:0] ctr_exp();
        logic [63:0] w = '0;
        int s;
        if (m_evt < 1 || m_evt > 3 || m_srm > 63) begin w[63] = 1'b1; return w; end
        s = find(m_srm);
        if (m_evt == 1 || s < 0) begin w[62] = 1'b1; return w; end
        w[CW-1:0] = CW'((m_evt == 2) ? m_tot[s] : m_loc[s]);
        return w;
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One cycle: drive, advance model at the edge, compare the response.
    task automatic step(input bit rv, input bit rw, input logic [3:0] a,
                        input logic [63:0] d, input bit ev, input int et,
                        input bit el, input bit eio, input string tag);
        logic        e_err;
        logic [63:0] e_dat;
        int          victim, es, r;
        int          post[4];
        req_valid = rv; req_write = rw; req_addr = a; req_wdata = d;
        ev_valid = ev; ev_thread = 2'(et); ev_local = el; ev_io = eio;
        e_err = 1'b0; e_dat = '0;
        if (rv && rw) e_err = !wr_ok(a, d);
        else if (rv) begin
            if (a < 4) e_dat = 64'(m_asn[a]);
            else if (a == 4'hE) e_dat = (64'(m_srm) << 32) | 64'(m_evt);
            else if (a == 4'hF) e_dat = ctr_exp();
            else e_err = 1'b1;
        end
        @(posedge clk);
        victim = -1; r = int'(d[9:0]);
        es = (ev && !eio) ? find(m_asn[et]) : -1;
        if (rv && rw && wr_ok(a, d) && a < 4) begin
            post = m_asn;
            post[a] = r;
            if (find(r) < 0) begin
                for (int s = 0; s < 8; s++) if (!m_vld[s] && victim < 0) victim = s;
                for (int s = 0; s < 8; s++) begin
                    bit h = 1'b0;
                    for (int t = 0; t < 4; t++) if (post[t] == m_rm[s]) h = 1'b1;
                    if (!h && victim < 0) victim = s;
                end
            end
        end
        if (es >= 0 && es != victim) begin
            m_tot[es] = (m_tot[es] + 1) & MSK;
            if (el) m_loc[es] = (m_loc[es] + 1) & MSK;
        end
        if (victim >= 0) begin
            m_vld[victim] = 1'b1; m_rm[victim] = r;
            m_tot[victim] = 0; m_loc[victim] = 0;
        end
        if (rv && rw && wr_ok(a, d)) begin
            if (a < 4) m_asn[a] = r;
            else begin m_evt = int'(d[7:0]); m_srm = int'(d[41:32]); end
        end
        @(negedge clk);
        chk({tag, " R3 valid"}, 64'(rsp_valid), 64'(rv));
        if (rv) begin
            chk({tag, " err"}, 64'(rsp_err), 64'(e_err));
            chk({tag, " data"}, rsp_rdata, e_dat);
        end
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        step(1, 0, a, '0, 0, 0, 0, 0, tag);
    endtask
    task automatic wr(input logic [3:0] a, input logic [63:0] d, input string tag);
        step(1, 1, a, d, 0, 0, 0, 0, tag);
    endtask
    function automatic logic [63:0] sel(input int rm, input int id);
        return (64'(rm) << 32) | 64'(id);
    endfunction

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int t = 0; t < 4; t++) m_asn[t] = 0;
        for (int s = 0; s < 8; s++) begin
            m_vld[s] = (s == 0); m_rm[s] = 0; m_tot[s] = 0; m_loc[s] = 0;
        end
        m_evt = 0; m_srm = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        for (int t = 0; t < 4; t++) rd(4'(t), "R1 assoc");
        rd(4'hE, "R1 select");
        rd(4'hF, "R1 R6 bad code 0");
        wr(4'hE, sel(0, 2), "R2 select");
        rd(4'hE, "R2 select back");
        rd(4'hF, "R1 zero count");

        // R10 wrap with local traffic, R4 counting
        for (int i = 0; i < 70; i++) step(0, 0, 0, '0, 1, 0, 1, 0, "R4 idle");
        rd(4'hF, "R10 total wrapped");
        wr(4'hE, sel(0, 3), "R5 select local");
        rd(4'hF, "R5 local");
        for (int i = 0; i < 5; i++) step(0, 0, 0, '0, 1, 0, 1, 1, "R4 io");
        rd(4'hF, "R4 io ignored");
        // R11 read and event in the same cycle
        step(1, 0, 4'hF, '0, 1, 0, 1, 0, "R11 same cycle");
        rd(4'hF, "R11 after");

        // R2 rejected writes
        wr(4'hE, sel(0, 2) | 64'h100, "R2 reserved");
        wr(4'hE, sel(300, 2), "R2 rmid limit");
        wr(4'h1, 64'h0010_0005, "R2 assoc reserved");
        wr(4'h1, 64'd256, "R2 assoc limit");
        rd(4'h1, "R2 assoc kept");
        rd(4'hE, "R2 select kept");
        // R3 illegal targets
        wr(4'hF, 64'd1, "R3 counter write");
        rd(4'h9, "R3 unmapped read");
        wr(4'h9, 64'd1, "R3 unmapped write");

        // R6 / R7
        wr(4'hE, sel(70, 2), "R6 select");
        rd(4'hF, "R6 rmid above limit");
        wr(4'hE, sel(0, 5), "R6 select");
        rd(4'hF, "R6 bad code");
        wr(4'hE, sel(0, 1), "R7 select");
        rd(4'hF, "R7 occupancy");
        wr(4'hE, sel(5, 2), "R7 select");
        rd(4'hF, "R7 untracked");

        // R8 claim and reuse
        wr(4'h1, 64'd5, "R8 assoc");
        rd(4'hF, "R8 cleared");
        for (int i = 0; i < 3; i++) step(0, 0, 0, '0, 1, 1, 0, 0, "R8 idle");
        rd(4'hF, "R8 counted");
        wr(4'h2, 64'd5, "R8 shared");
        rd(4'hF, "R8 kept");

        // R9 fill all slots then evict
        for (int r = 6; r <= 12; r++) wr(4'h3, 64'(r), "R9 assoc");
        wr(4'hE, sel(6, 2), "R9 select");
        rd(4'hF, "R9 evicted");
        wr(4'hE, sel(7, 2), "R9 select");
        rd(4'hF, "R9 survivor");
        wr(4'hE, sel(5, 2), "R9 select");
        rd(4'hF, "R9 held");

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            bit rv = ($urandom_range(0, 1) == 1);
            bit rw = ($urandom_range(0, 1) == 1);
            int k = $urandom_range(0, 99);
            logic [3:0]  a;
            logic [63:0] d = '0;
            if (k < 40) a = 4'($urandom_range(0, 3));
            else if (k < 65) a = 4'hE;
            else if (k < 92) a = 4'hF;
            else a = 4'($urandom_range(0, 15));
            if (a == 4'hE) begin
                d = sel(($urandom_range(0, 9) == 0) ? $urandom_range(0, 300)
                                                    : $urandom_range(0, 14),
                        $urandom_range(0, 4));
            end else begin
                d = 64'(($urandom_range(0, 9) == 0) ? $urandom_range(0, 300)
                                                    : $urandom_range(0, 14));
            end
            if ($urandom_range(0, 19) == 0) d[$urandom_range(10, 63)] = 1'b1;
            step(rv, rw, a, d, ($urandom_range(0, 9) < 7), $urandom_range(0, 3),
                 $urandom_range(0, 1) == 1, $urandom_range(0, 9) == 0,
                 "R4 R8 R9 R11 random");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule